// File: doc/BRIEF.md
# CRC-Checked SPI Register Access Master

This block is an SPI master that performs one register read or one register write on a data converter's configuration space per request. A requester presents a 7-bit register address, a read/write flag and a write byte on a valid/ready port. The block forms a three-byte frame: an instruction byte, a data byte and a CRC-8 byte. It shifts the frame out in SPI mode 0 while chip select stays low for the whole frame, and it captures the three bytes that come back at the same time.

On completion the block pulses `done` for one clock. In that cycle it presents the second returned byte as read data and a flag that shows whether the returned third byte differs from the CRC that was sent. A request for an address above the top of the register map is refused at once with an address-error flag, and no bus activity takes place. The serial clock is an even division of the system clock. A minimum idle time is kept between frames.

Top module: `crcspi_master`

## Requirements
- R1: Each accepted frame is exactly 24 bits sent MSB first on `spi_mosi`: an instruction byte whose bit 7 is 1 for a read and 0 for a write and whose bits 6:0 hold the address, then a data byte, then a CRC byte.
- R2: The CRC byte is CRC-8 with polynomial 0x07 and initial value 0xA5, processed MSB first over the instruction byte followed by the data byte.
- R3: For a read the data byte sent is 0x00, whatever `req_wdata` holds, and the CRC covers that zero byte.
- R4: `rdata` equals the second byte received on `spi_miso` during the frame. This holds for reads and for writes.
- R5: `crc_error` is 1 when the third received byte differs from the third sent byte and 0 when they match. The transaction completes and returns `rdata` in both cases.
- R6: SPI mode 0: `spi_sclk` idles low and has a period of CLK_DIV system clocks. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled on the rising edge.
- R7: `spi_cs_n` falls CLK_DIV/2 system clocks before the first rising edge of `spi_sclk` and rises CLK_DIV/2 system clocks after the 24th falling edge. There are exactly 24 rising edges per frame.
- R8: After `spi_cs_n` rises, `req_ready` stays low for IDLE_HALVES×CLK_DIV/2 system clocks, counted from the `done` cycle.
- R9: A request is taken when `req_valid` and `req_ready` are both 1. `done` is high for exactly one clock per request. `rdata`, `crc_error` and `addr_error` are valid in that cycle and hold their values until the next `done`.
- R10: A request with an address above MAX_ADDR (0x48) gives `done` with `addr_error`=1 and `crc_error`=0 on the next clock. `spi_cs_n` stays high.
- R11: After reset `spi_cs_n`=1, `spi_sclk`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Second byte received in the frame |
| crc_error | output | 1 | Echoed CRC differs from the CRC sent |
| addr_error | output | 1 | Request refused because the address is out of range |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A returned read value and a CRC mismatch arrive in the same `done` cycle. The bench provokes this with a slave model that returns a register byte while corrupting the echoed CRC on about a quarter of the frames, including chosen reads. It then requires `crc_error`=1 together with the correct `rdata` in that single cycle. The bench also presents an out-of-range address straight after a valid frame. It judges that the refusal pulse comes one clock after acceptance and that no chip-select edge occurs.

// File: rtl/crcspi_pkg.sv
package crcspi_pkg;
   localparam int BYTE_W     = 8;
   localparam int ADDR_W     = 7;
   localparam int FRAME_BITS = 3 * BYTE_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_TRAIL,
      ST_GAP
   } phase_t;
endpackage

// File: rtl/crcspi_crc8.sv
// Combinational MSB-first CRC over DATA_W bits, unrolled one stage per bit.
module crcspi_crc8 #(
   parameter int          DATA_W = 16,
   parameter logic [7:0]  POLY   = 8'h07,
   parameter logic [7:0]  SEED   = 8'hA5
) (
   input  logic [DATA_W-1:0] data_in,
   output logic [7:0]        crc_out
);
   logic [7:0] stage [DATA_W+1];

   assign stage[0] = SEED;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb = stage[i][7] ^ data_in[DATA_W-1-i];
      assign stage[i+1] = {stage[i][6:0], 1'b0} ^ (fb ? POLY : 8'h00);
   end

   assign crc_out = stage[DATA_W];
endmodule

// File: rtl/crcspi_halftick.sv
// Emits one tick every HALF system clocks while run is high.
module crcspi_halftick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (HALF < 1) begin : g_bad_half
      $error("HALF must be at least 1");
   end

   if (HALF == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int CNT_W = $clog2(HALF);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!run || cnt == CNT_W'(HALF - 1)) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = run && (cnt == CNT_W'(HALF - 1));

      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CNT_W'(HALF - 1)); // R6
   end
endmodule

// File: rtl/crcspi_shift24.sv
// Frame shift register: loads a transmit word, shifts it out MSB first and
// collects received bits.
module crcspi_shift24 #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               sample,
   input  logic               advance,
   input  logic               miso,
   output logic               mosi,
   output logic [FRAME_W-1:0] rx_word,
   output logic               last
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] rx_q;
   logic [CNT_W-1:0]   bit_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_q    <= '0;
         bit_cnt <= '0;
      end else begin
         if (load) begin
            tx_q    <= load_word;
            bit_cnt <= '0;
         end else begin
            if (advance) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            if (sample) begin
               rx_q    <= {rx_q[FRAME_W-2:0], miso};
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign mosi    = tx_q[FRAME_W-1];
   assign rx_word = rx_q;
   assign last    = (bit_cnt == CNT_W'(FRAME_W));

   AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W)); // R7
   AST_NO_SAMPLE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> !sample); // R7
endmodule

// File: rtl/crcspi_master.sv
module crcspi_master
   import crcspi_pkg::*;
#(
   parameter int         CLK_DIV     = 4,
   parameter int         IDLE_HALVES = 2,
   parameter logic [6:0] MAX_ADDR    = 7'h48,
   parameter logic [7:0] CRC_POLY    = 8'h07,
   parameter logic [7:0] CRC_SEED    = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   output logic       req_ready,
   input  logic       req_read,
   input  logic [6:0] req_addr,
   input  logic [7:0] req_wdata,
   output logic       done,
   output logic [7:0] rdata,
   output logic       crc_error,
   output logic       addr_error,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int GAP_W = (IDLE_HALVES < 2) ? 1 : $clog2(IDLE_HALVES);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (IDLE_HALVES < 1) begin : g_bad_gap
      $error("IDLE_HALVES must be at least 1");
   end

   phase_t                 state;
   logic                   tick;
   logic                   run;
   logic                   accept;
   logic                   bad_addr;
   logic [BYTE_W-1:0]      inst_b;
   logic [BYTE_W-1:0]      data_b;
   logic [BYTE_W-1:0]      crc_b;
   logic [BYTE_W-1:0]      crc_q;
   logic [FRAME_BITS-1:0]  rx_word;
   logic                   last_bit;
   logic                   sample;
   logic                   advance;
   logic [GAP_W-1:0]       gap_cnt;

   assign inst_b   = {req_read, req_addr};
   assign data_b   = req_read ? '0 : req_wdata;
   assign bad_addr = (req_addr > MAX_ADDR);
   assign req_ready = (state == ST_IDLE) && !done;
   assign accept   = req_valid && req_ready;
   assign run      = (state != ST_IDLE);
   assign sample   = tick && (state == ST_LEAD || state == ST_LOW);
   assign advance  = tick && (state == ST_HIGH) && !last_bit;

   crcspi_crc8 #(
      .DATA_W (2 * BYTE_W),
      .POLY   (CRC_POLY),
      .SEED   (CRC_SEED)
   ) u_crc (
      .data_in (({inst_b, data_b})),
      .crc_out (crc_b)
   );

   crcspi_halftick #(
      .HALF (HALF)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   crcspi_shift24 #(
      .FRAME_W (FRAME_BITS)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && !bad_addr),
      .load_word ({inst_b, data_b, crc_b}),
      .sample    (sample),
      .advance   (advance),
      .miso      (spi_miso),
      .mosi      (spi_mosi),
      .rx_word   (rx_word),
      .last      (last_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         spi_cs_n   <= 1'b1;
         spi_sclk   <= 1'b0;
         done       <= 1'b0;
         rdata      <= '0;
         crc_error  <= 1'b0;
         addr_error <= 1'b0;
         crc_q      <= '0;
         gap_cnt    <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (bad_addr) begin
                     done       <= 1'b1;
                     addr_error <= 1'b1;
                     crc_error  <= 1'b0;
                     rdata      <= '0;
                  end else begin
                     spi_cs_n <= 1'b0;
                     crc_q    <= crc_b;
                     state    <= ST_LEAD;
                  end
               end
            end
            ST_LEAD, ST_LOW: begin
               if (tick) begin
                  spi_sclk <= 1'b1;
                  state    <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  spi_sclk <= 1'b0;
                  state    <= last_bit ? ST_TRAIL : ST_LOW;
               end
            end
            ST_TRAIL: begin
               if (tick) begin
                  spi_cs_n   <= 1'b1;
                  done       <= 1'b1;
                  rdata      <= rx_word[2*BYTE_W-1:BYTE_W];
                  crc_error  <= (rx_word[BYTE_W-1:0] != crc_q);
                  addr_error <= 1'b0;
                  gap_cnt    <= '0;
                  state      <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_cnt == GAP_W'(IDLE_HALVES - 1)) state <= ST_IDLE;
                  else gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({rdata, crc_error, addr_error})); // R9
   AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && bad_addr) |=> (spi_cs_n && done && addr_error && !crc_error)); // R10
   AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> spi_cs_n); // R8
   AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R6
endmodule

// File: tb/crcspi_master_bench.sv
`timescale 1ns/1ps
module crcspi_master_bench;
   localparam int         CLK_DIV     = 4;
   localparam int         HALF        = CLK_DIV / 2;
   localparam int         IDLE_HALVES = 3;
   localparam logic [6:0] MAX_ADDR    = 7'h48;
   localparam time        TCLK        = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_read = 1'b0;
   logic [6:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       done;
   logic [7:0] rdata;
   logic       crc_error;
   logic       addr_error;
   logic       spi_sclk;
   logic       spi_cs_n;
   logic       spi_mosi;
   logic       spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #(TCLK/2) clk = ~clk;

   crcspi_master #(
      .CLK_DIV     (CLK_DIV),
      .IDLE_HALVES (IDLE_HALVES),
      .MAX_ADDR    (MAX_ADDR)
   ) u_crcspi_master (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_read   (req_read),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .done       (done),
      .rdata      (rdata),
      .crc_error  (crc_error),
      .addr_error (addr_error),
      .spi_sclk   (spi_sclk),
      .spi_cs_n   (spi_cs_n),
      .spi_mosi   (spi_mosi),
      .spi_miso   (spi_miso)
   );

   // Slave model
   logic [7:0]  regs [128];
   logic [23:0] resp = '0;
   logic [23:0] cap = '0;
   int          rises = 0;
   int          bit_idx = 0;
   int          cs_falls = 0;
   time         t_csfall = 0, t_rise_first = 0, t_rise_last = 0;
   time         t_fall_last = 0, t_csrise = 0;

   always @(negedge spi_cs_n) begin
      cs_falls++;
      t_csfall = $time;
      cap      = '0;
      rises    = 0;
      spi_miso = resp[23];
      bit_idx  = 22;
   end
   always @(posedge spi_sclk) if (!spi_cs_n) begin
      cap = {cap[22:0], spi_mosi};
      if (rises == 0) t_rise_first = $time;
      t_rise_last = $time;
      rises++;
   end
   always @(negedge spi_sclk) if (!spi_cs_n) begin
      t_fall_last = $time;
      if (bit_idx >= 0) begin
         spi_miso = resp[bit_idx];
         bit_idx--;
      end
   end
   always @(posedge spi_cs_n) t_csrise = $time;

   function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b);
      logic [7:0]  c = 8'hA5;
      logic [15:0] d = {a, b};
      for (int i = 15; i >= 0; i--) begin
         logic fb = c[7] ^ d[i];
         c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic txn(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                      input bit corrupt);
      bit         bad = (a > MAX_ADDR);
      logic [7:0] inst = {rd, a};
      logic [7:0] dat = rd ? 8'h00 : wd;
      logic [7:0] c = ref_crc(inst, dat);
      logic [7:0] reg_old = regs[a];
      int         falls0;
      int         n = 0;
      resp = {8'h3C, reg_old, corrupt ? (c ^ 8'h5A) : c};
      while (!req_ready) @(negedge clk);
      falls0    = cs_falls;
      req_valid = 1'b1;
      req_read  = rd;
      req_addr  = a;
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(done, "R9", "done seen", done, 1);
      if (bad) begin
         chk(n == 0, "R10", "reject latency", n, 0);
         chk(addr_error, "R10", "addr_error", addr_error, 1);
         chk(!crc_error, "R10", "crc_error on reject", crc_error, 0);
         chk(cs_falls == falls0, "R10", "cs activity", cs_falls - falls0, 0);
         @(negedge clk);
         chk(!done, "R9", "done width", done, 0);
      end else begin
         chk(cap == {inst, dat, c}, "R1", "mosi frame", cap, {inst, dat, c});
         chk(cap[7:0] == c, "R2", "crc byte", cap[7:0], c);
         if (rd) chk(cap[15:8] == 8'h00, "R3", "read data byte", cap[15:8], 0);
         chk(rises == 24, "R7", "rising edges", rises, 24);
         chk(rdata == reg_old, "R4", "rdata", rdata, reg_old);
         chk(crc_error == corrupt, "R5", "crc_error", crc_error, corrupt);
         chk(!addr_error, "R9", "addr_error", addr_error, 0);
         chk(t_rise_first - t_csfall == HALF * TCLK, "R7", "cs lead ns",
             32'(t_rise_first - t_csfall), HALF * TCLK);
         chk(t_csrise - t_fall_last == HALF * TCLK, "R7", "cs trail ns",
             32'(t_csrise - t_fall_last), HALF * TCLK);
         chk(t_rise_last - t_rise_first == 23 * CLK_DIV * TCLK, "R6", "sclk span ns",
             32'(t_rise_last - t_rise_first), 23 * CLK_DIV * TCLK);
         n = 0;
         while (!req_ready && n < 200) begin
            @(negedge clk);
            n++;
            if (n == 1) chk(!done, "R9", "done width", done, 0);
         end
         chk(n == IDLE_HALVES * HALF, "R8", "idle gap", n, IDLE_HALVES * HALF);
         if (!rd) regs[a] = wd;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 128; i++) regs[i] = 8'(i * 37 + 5);
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R11 reset state
      chk(spi_cs_n == 1'b1, "R11", "cs_n in reset", spi_cs_n, 1);
      chk(spi_sclk == 1'b0, "R11", "sclk in reset", spi_sclk, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R11", "done after reset", done, 0);
      chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);

      // Directed corners
      txn(1'b1, 7'h48, 8'hFF, 1'b0);   // top valid address, read ignores wdata (R3)
      txn(1'b1, 7'h49, 8'h00, 1'b0);   // first invalid address (R10)
      txn(1'b0, 7'h10, 8'hA7, 1'b0);   // write
      txn(1'b1, 7'h10, 8'h00, 1'b1);   // read back with bad echo (R5 with R4)
      txn(1'b1, 7'h7F, 8'h12, 1'b0);   // top of address space refused (R10)
      txn(1'b0, 7'h00, 8'h00, 1'b1);   // write with bad echo (R5)
      chk(rdata == 8'h05, "R4", "held rdata after write", rdata, 8'h05);

      // Random mix
      for (int k = 0; k < 40; k++) begin
         bit         rd = $urandom_range(0, 1) == 1;
         logic [6:0] a  = 7'($urandom_range(0, 127));
         logic [7:0] wd = 8'($urandom_range(0, 255));
         bit         cr = $urandom_range(0, 3) == 0;
         txn(rd, a, wd, cr);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule